// File: doc/BRIEF.md
# Serial Audio Link Receive Frame Deserializer

This block takes the incoming frame of a serial audio codec link (a bit clock, a frame sync and a single serial data line) and splits it into the fields a controller needs. A frame holds 256 bits. The first 16 bits are a tag word that marks the whole frame valid and marks each of the first four data slots valid. Four 20-bit slots follow: a register status slot, a register data slot, and the left and right record samples. The rest of the frame is unused.

Serial data is sampled on the falling edge of the bit clock, most significant bit first. A rising edge of the sync line marks the first tag bit. All decoded fields are registered together when the last bit of the frame arrives, and a one-cycle done pulse marks that update. A frame whose tag says it is invalid leaves every field and flag as it was. The sample request flags carried in the status slot are passed on only while the variable-rate input is high. A sync rising edge in the middle of a frame restarts the bit count, and the partial frame is dropped.

Top module: `alk_rx_deframer`

## Requirements
- R1: While reset is held low and after its release, before any complete frame, every output is 0.
- R2: The bit sampled at the falling edge where sync is first seen high is tag bit 15; bits follow MSB first, one per falling edge. frame_done goes high for exactly one cycle after the 256th bit, and two done pulses are at least 255 cycles apart.
- R3: When tag bit 15 is 0, frame_done still pulses but no field and no valid or request flag changes.
- R4: Tag bits 3, 4, 5 and 6 mark slots 1, 2, 3 and 4 valid. Tag bits 14-7 and 2-0 have no effect on any output.
- R5: In a valid frame with slot 1 valid, reg_addr takes slot 1 bits 18-12 and reg_addr_vld is 1. With slot 1 invalid, reg_addr_vld is 0 and reg_addr holds.
- R6: reg_data takes slot 2 bits 19-4 and reg_data_vld is 1 only when slots 1 and 2 are both valid. Otherwise reg_data_vld is 0 and reg_data holds.
- R7: req_left equals slot 1 bit 11 and req_right equals slot 1 bit 10 when slot 1 is valid and var_rate_en is high at the last bit. Otherwise both are 0.
- R8: rec_left takes slot 3 bits 19-4 and rec_right takes slot 4 bits 19-4, with bits 3-0 dropped. Each has a valid flag equal to its slot flag, and its data holds while the slot is invalid.
- R9: A sync rising edge before the frame's last bit discards the partial frame: no done pulse, and the new frame is counted from its first tag bit.
- R10: Bits in slots 5 to 12 have no effect on any output.
- R11: No output other than frame_done changes in a cycle without a frame_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame sync; a rising edge marks the first tag bit |
| sdin | input | 1 | Serial frame data, MSB first |
| var_rate_en | input | 1 | Variable-rate mode; when low the request flags are forced to 0 |
| frame_done | output | 1 | One-cycle pulse when a complete frame has been decoded |
| reg_addr | output | 7 | Echoed register address |
| reg_addr_vld | output | 1 | Status slot valid in the last valid frame |
| reg_data | output | 16 | Register read data |
| reg_data_vld | output | 1 | Status and data slots both valid in the last valid frame |
| req_left | output | 1 | Left sample request |
| req_right | output | 1 | Right sample request |
| rec_left | output | 16 | Left record sample |
| rec_left_vld | output | 1 | Left sample slot valid in the last valid frame |
| rec_right | output | 16 | Right record sample |
| rec_right_vld | output | 1 | Right sample slot valid in the last valid frame |

## Verification
The bench uses the default frame length of 256 bits, so the same run reaches the full tag decode, all four captured slots and the unused tail of the frame. That length lets it test the last-bit corner directly: a frame cut off after 255 bits, a frame cut off after 100 bits, and a tail filled with ones and with random bits. Held values are checked by following frames with an invalid tag and with single-slot tags after frames with all slots valid, so that every stale field can be told apart from a fresh one.

// File: rtl/alk_pkg.sv
package alk_pkg;
    // Frame format constants: the field positions are behaviour
    localparam int TAG_W         = 16;
    localparam int SLOT_W        = 20;
    localparam int SMP_W         = 16;
    localparam int ADDR_W        = 7;
    localparam int USED_SLOTS    = 4;
    localparam int CAP_W         = TAG_W + USED_SLOTS * SLOT_W;
    localparam int FRAME_OK_BIT  = 15;
    localparam int SLOT_FLAG_LSB = 3;
    localparam int ADDR_MSB      = 18;
    localparam int REQ_L_BIT     = 11;
    localparam int REQ_R_BIT     = 10;

    typedef struct packed {
        logic                  frame_ok;
        logic [USED_SLOTS-1:0] slot_ok;   // slot_ok[n-1] belongs to slot n
        logic [ADDR_W-1:0]     addr;
        logic                  req_l;
        logic                  req_r;
        logic [SMP_W-1:0]      rdata;
        logic [SMP_W-1:0]      left;
        logic [SMP_W-1:0]      right;
    } alk_fields_t;

    typedef struct packed {
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic              addr_vld;
        logic [SMP_W-1:0]  rdata;
        logic              rdata_vld;
        logic              req_l;
        logic              req_r;
        logic [SMP_W-1:0]  left;
        logic              left_vld;
        logic [SMP_W-1:0]  right;
        logic              right_vld;
    } alk_out_t;
endpackage

// File: rtl/alk_framer.sv
module alk_framer #(
    parameter int FRAME_BITS = 256,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             take,
    output logic [CNT_W-1:0] idx,
    output logic             last
);
    typedef struct packed {
        logic             sync_seen;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } fr_state_t;

    fr_state_t st_q, st_d;
    logic      start;

    always_comb begin
        st_d           = st_q;
        start          = sync & ~st_q.sync_seen;
        idx            = start ? '0 : st_q.cnt;
        take           = start | st_q.active;
        last           = take && (idx == CNT_W'(FRAME_BITS - 1));
        st_d.sync_seen = sync;
        if (take) begin
            st_d.cnt    = idx + 1'b1;
            st_d.active = ~last;
        end
        if (last) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/alk_capture.sv
module alk_capture #(
    parameter int CAP_W = 96,
    parameter int CNT_W = 8
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CNT_W-1:0] idx,
    input  logic             sdin,
    output logic [CAP_W-1:0] cap
);
    logic [CAP_W-1:0] cap_q, cap_d;

    always_comb begin
        cap_d = cap_q;
        if (take && (idx < CNT_W'(CAP_W))) begin
            cap_d = {cap_q[CAP_W-2:0], sdin};
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap = cap_q;
endmodule

// File: rtl/alk_slot_decode.sv
module alk_slot_decode
    import alk_pkg::*;
(
    input  logic [CAP_W-1:0] cap,
    input  logic             var_rate_en,
    output alk_fields_t      fields
);
    logic [TAG_W-1:0]  tag;
    logic [SLOT_W-1:0] slot [USED_SLOTS];
    logic              unused_bits;

    assign tag = cap[CAP_W-1 -: TAG_W];

    for (genvar n = 0; n < USED_SLOTS; n++) begin : g_slot
        assign slot[n] = cap[CAP_W-TAG_W-1-SLOT_W*n -: SLOT_W];
    end

    always_comb begin
        fields          = '0;
        fields.frame_ok = tag[FRAME_OK_BIT];
        fields.slot_ok  = tag[SLOT_FLAG_LSB +: USED_SLOTS];
        fields.addr     = slot[0][ADDR_MSB -: ADDR_W];
        fields.req_l    = slot[0][REQ_L_BIT] & var_rate_en & fields.slot_ok[0];
        fields.req_r    = slot[0][REQ_R_BIT] & var_rate_en & fields.slot_ok[0];
        fields.rdata    = slot[1][SLOT_W-1 -: SMP_W];
        fields.left     = slot[2][SLOT_W-1 -: SMP_W];
        fields.right    = slot[3][SLOT_W-1 -: SMP_W];
    end

    // Reserved tag flags, slot-1 spare bits and the sample low nibbles
    assign unused_bits = ^{tag[FRAME_OK_BIT-1:SLOT_FLAG_LSB+USED_SLOTS],
                           tag[SLOT_FLAG_LSB-1:0], slot[0][SLOT_W-1],
                           slot[0][REQ_R_BIT-1:0], slot[1][SLOT_W-SMP_W-1:0],
                           slot[2][SLOT_W-SMP_W-1:0], slot[3][SLOT_W-SMP_W-1:0]};
endmodule

// File: rtl/alk_rx_deframer.sv
module alk_rx_deframer
    import alk_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              sdin,
    input  logic              var_rate_en,
    output logic              frame_done,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_addr_vld,
    output logic [SMP_W-1:0]  reg_data,
    output logic              reg_data_vld,
    output logic              req_left,
    output logic              req_right,
    output logic [SMP_W-1:0]  rec_left,
    output logic              rec_left_vld,
    output logic [SMP_W-1:0]  rec_right,
    output logic              rec_right_vld
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    logic             take, last;
    logic [CNT_W-1:0] idx;
    logic [CAP_W-1:0] cap;
    alk_fields_t      fields;
    alk_out_t         out_q, out_d;

    alk_framer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_framer (
        .bclk(bclk), .rst_n(rst_n), .sync(sync),
        .take(take), .idx(idx), .last(last)
    );

    alk_capture #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_capture (
        .bclk(bclk), .rst_n(rst_n), .take(take), .idx(idx),
        .sdin(sdin), .cap(cap)
    );

    alk_slot_decode u_decode (
        .cap(cap), .var_rate_en(var_rate_en), .fields(fields)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = 1'b0;
        if (last) begin
            out_d.done = 1'b1;
            if (fields.frame_ok) begin
                out_d.addr_vld  = fields.slot_ok[0];
                out_d.rdata_vld = fields.slot_ok[0] & fields.slot_ok[1];
                out_d.left_vld  = fields.slot_ok[2];
                out_d.right_vld = fields.slot_ok[3];
                out_d.req_l     = fields.req_l;
                out_d.req_r     = fields.req_r;
                if (fields.slot_ok[0])                      out_d.addr  = fields.addr;
                if (fields.slot_ok[0] && fields.slot_ok[1]) out_d.rdata = fields.rdata;
                if (fields.slot_ok[2])                      out_d.left  = fields.left;
                if (fields.slot_ok[3])                      out_d.right = fields.right;
            end
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign frame_done    = out_q.done;
    assign reg_addr      = out_q.addr;
    assign reg_addr_vld  = out_q.addr_vld;
    assign reg_data      = out_q.rdata;
    assign reg_data_vld  = out_q.rdata_vld;
    assign req_left      = out_q.req_l;
    assign req_right     = out_q.req_r;
    assign rec_left      = out_q.left;
    assign rec_left_vld  = out_q.left_vld;
    assign rec_right     = out_q.right;
    assign rec_right_vld = out_q.right_vld;
endmodule

// File: rtl/alk_rx_deframer_chk.sv
module alk_rx_deframer_chk #(
    parameter int FRAME_BITS = 256
) (
    input logic        bclk,
    input logic        rst_n,
    input logic        var_rate_en,
    input logic        frame_done,
    input logic [6:0]  reg_addr,
    input logic        reg_addr_vld,
    input logic [15:0] reg_data,
    input logic        reg_data_vld,
    input logic        req_left,
    input logic        req_right,
    input logic [15:0] rec_left,
    input logic        rec_left_vld,
    input logic [15:0] rec_right,
    input logic        rec_right_vld
);
    localparam int GAP_W = $clog2(FRAME_BITS) + 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n)                                  gap_q <= '0;
        else if (frame_done)                         gap_q <= '0;
        else if (gap_q != GAP_W'(FRAME_BITS))        gap_q <= gap_q + 1'b1;
    end

    // R2: done pulses last one cycle and are a frame apart
    assert_done_single_R2: assert property (@(negedge bclk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    assert_done_spacing_R2: assert property (@(negedge bclk) disable iff (!rst_n)
        frame_done |-> (gap_q >= GAP_W'(FRAME_BITS - 1)));

    // R6: register data cannot be valid without the status slot
    assert_data_needs_addr_R6: assert property (@(negedge bclk) disable iff (!rst_n)
        reg_data_vld |-> reg_addr_vld);

    // R7: requests masked by the mode input and by the status slot flag
    assert_req_masked_R7: assert property (@(negedge bclk) disable iff (!rst_n)
        (frame_done && !$past(var_rate_en)) |-> (!req_left && !req_right));
    assert_req_needs_slot_R7: assert property (@(negedge bclk) disable iff (!rst_n)
        (req_left || req_right) |-> reg_addr_vld);

    // R11: fields only move together with a done pulse
    assert_hold_between_R11: assert property (@(negedge bclk) disable iff (!rst_n)
        !frame_done |-> ($stable(reg_addr) && $stable(reg_data) && $stable(rec_left)
                         && $stable(rec_right) && $stable(reg_addr_vld)
                         && $stable(reg_data_vld) && $stable(rec_left_vld)
                         && $stable(rec_right_vld) && $stable(req_left)
                         && $stable(req_right)));
endmodule

bind alk_rx_deframer alk_rx_deframer_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (.*);

// File: tb/sim_alk_rx_deframer.sv
module sim_alk_rx_deframer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync = 1'b0;
    logic sdin = 1'b0;
    logic var_rate_en = 1'b0;
    logic        frame_done;
    logic [6:0]  reg_addr;
    logic        reg_addr_vld;
    logic [15:0] reg_data;
    logic        reg_data_vld;
    logic        req_left, req_right;
    logic [15:0] rec_left, rec_right;
    logic        rec_left_vld, rec_right_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [6:0]  addr;
        logic        addr_vld;
        logic [15:0] data;
        logic        data_vld;
        logic        rl;
        logic        rr;
        logic [15:0] left;
        logic        lv;
        logic [15:0] right;
        logic        rv;
    } exp_t;

    exp_t  model = '0;
    exp_t  exp_q[$];
    string ctx_q[$];

    always #10 clk = ~clk;  // 50 MHz

    alk_rx_deframer u0 (
        .bclk(clk), .rst_n(rst_n), .sync(sync), .sdin(sdin),
        .var_rate_en(var_rate_en), .frame_done(frame_done),
        .reg_addr(reg_addr), .reg_addr_vld(reg_addr_vld),
        .reg_data(reg_data), .reg_data_vld(reg_data_vld),
        .req_left(req_left), .req_right(req_right),
        .rec_left(rec_left), .rec_left_vld(rec_left_vld),
        .rec_right(rec_right), .rec_right_vld(rec_right_vld)
    );

    function automatic exp_t snap();
        return {reg_addr, reg_addr_vld, reg_data, reg_data_vld, req_left, req_right,
                rec_left, rec_left_vld, rec_right, rec_right_vld};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] mk_s1(input logic [6:0] a, input logic l, input logic r);
        return {1'b0, a, l, r, 10'h0};
    endfunction

    // Drive nbits of a frame; a complete frame updates the model and is queued
    task automatic send_frame(input string ctx, input logic [15:0] tag,
                              input logic [19:0] s1, input logic [19:0] s2,
                              input logic [19:0] s3, input logic [19:0] s4,
                              input logic vre, input int nbits,
                              input logic [159:0] tail);
        logic [255:0] fr;
        fr = {tag, s1, s2, s3, s4, tail};
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk);
            sync = (i < 16);
            sdin = fr[255-i];
            if (i == 0) var_rate_en = vre;
        end
        if (nbits == 256) begin
            if (tag[15]) begin
                model.addr_vld = tag[3];
                model.data_vld = tag[3] & tag[4];
                model.lv       = tag[5];
                model.rv       = tag[6];
                model.rl       = tag[3] & vre & s1[11];
                model.rr       = tag[3] & vre & s1[10];
                if (tag[3])          model.addr  = s1[18:12];
                if (tag[3] && tag[4]) model.data = s2[19:4];
                if (tag[5])          model.left  = s3[19:4];
                if (tag[6])          model.right = s4[19:4];
            end
            exp_q.push_back(model);
            ctx_q.push_back(ctx);
        end
    endtask

    // Monitor: compares results as they appear
    initial begin
        exp_t  prev = '0;
        exp_t  cur;
        exp_t  e;
        string c;
        forever begin
            @(posedge clk);
            cur = snap();
            if (rst_n && !finished) begin
                if (frame_done) begin
                    if (exp_q.size() == 0) begin
                        chk("R9", "done without a complete frame", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        c = ctx_q.pop_front();
                        chk(c, "R5 reg_addr", 64'(reg_addr), 64'(e.addr));
                        chk(c, "R4 R5 reg_addr_vld", 64'(reg_addr_vld), 64'(e.addr_vld));
                        chk(c, "R6 reg_data", 64'(reg_data), 64'(e.data));
                        chk(c, "R6 reg_data_vld", 64'(reg_data_vld), 64'(e.data_vld));
                        chk(c, "R7 requests", 64'({req_left, req_right}), 64'({e.rl, e.rr}));
                        chk(c, "R8 rec_left", 64'(rec_left), 64'(e.left));
                        chk(c, "R8 rec_right", 64'(rec_right), 64'(e.right));
                        chk(c, "R4 R8 sample valids", 64'({rec_left_vld, rec_right_vld}),
                            64'({e.lv, e.rv}));
                    end
                end else begin
                    chk("R11", "outputs moved without done", 64'(cur), 64'(prev));
                end
            end
            prev = cur;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] tag_all;
        tag_all = 16'h8078;
        repeat (4) @(posedge clk);
        chk("R1", "outputs in reset", 64'(snap()), 64'h0);
        chk("R1", "done in reset", 64'(frame_done), 64'h0);
        @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        chk("R1", "outputs after reset", 64'(snap()), 64'h0);

        send_frame("R2 all slots", tag_all, mk_s1(7'h2A, 1'b1, 1'b1),
                   20'hBEEF3, 20'h1234A, 20'hFEDC5, 1'b1, 256, '0);
        send_frame("R7 mode off", tag_all, mk_s1(7'h15, 1'b1, 1'b1),
                   20'h55AA7, 20'hA5A51, 20'h0F0F2, 1'b0, 256, '0);
        send_frame("R7 left only", tag_all, mk_s1(7'h33, 1'b1, 1'b0),
                   20'h13579, 20'h2468A, 20'h369CB, 1'b1, 256, '0);
        send_frame("R3 frame invalid", 16'h7FFF, mk_s1(7'h7F, 1'b1, 1'b1),
                   20'hFFFFF, 20'hFFFFF, 20'hFFFFF, 1'b1, 256, '0);
        send_frame("R4 slot1 only", 16'h8008, mk_s1(7'h01, 1'b0, 1'b1),
                   20'h11111, 20'h22222, 20'h33333, 1'b1, 256, '0);
        send_frame("R6 slot2 only", 16'h8010, mk_s1(7'h40, 1'b1, 1'b1),
                   20'hCAFE0, 20'h44444, 20'h55555, 1'b1, 256, '0);
        send_frame("R8 slot4 only", 16'h8040, mk_s1(7'h02, 1'b0, 1'b0),
                   20'h66666, 20'h77777, 20'h9ABCF, 1'b1, 256, '0);
        send_frame("R8 slot3 only", 16'h8020, mk_s1(7'h03, 1'b0, 1'b0),
                   20'h88888, 20'hDEAD7, 20'h99999, 1'b1, 256, '0);
        send_frame("R4 reserved tag bits", 16'hFF87, mk_s1(7'h7E, 1'b1, 1'b1),
                   20'hAAAAA, 20'hBBBBB, 20'hCCCCC, 1'b1, 256, {160{1'b1}});
        send_frame("R10 tail ones", 16'hFFFF, mk_s1(7'h5C, 1'b0, 1'b1),
                   20'h0FED1, 20'h70002, 20'h80003, 1'b1, 256, {160{1'b1}});
        send_frame("R10 tail random", tag_all, mk_s1(7'h26, 1'b1, 1'b0),
                   20'h31415, 20'h92653, 20'h58979, 1'b1, 256,
                   {5{$urandom()}});
        send_frame("R9 partial 100", tag_all, mk_s1(7'h11, 1'b1, 1'b1),
                   20'h11110, 20'h22220, 20'h33330, 1'b1, 100, '0);
        send_frame("R9 after partial 100", tag_all, mk_s1(7'h4B, 1'b0, 1'b1),
                   20'h76543, 20'h21098, 20'h87654, 1'b1, 256, '0);
        send_frame("R9 partial 255", tag_all, mk_s1(7'h12, 1'b1, 1'b1),
                   20'hFFFF0, 20'hEEEE0, 20'hDDDD0, 1'b1, 255, '0);
        send_frame("R9 after partial 255", tag_all, mk_s1(7'h6D, 1'b1, 1'b0),
                   20'h0ACE1, 20'h0BED2, 20'h0CAB3, 1'b1, 256, '0);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] t;
            t = 16'($urandom());
            t[15] = (k != 3);
            send_frame("R2 random", t, 20'($urandom()), 20'($urandom()),
                       20'($urandom()), 20'($urandom()), 1'($urandom()), 256,
                       {5{$urandom()}});
        end

        repeat (6) @(posedge clk);
        chk("R2 R9", "frames left unmatched", 64'(exp_q.size()), 64'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule